// File: doc/BRIEF.md
# Transmit Frame Launcher

This block is the send half of a small Ethernet MAC. The host places a complete wire image in memory: seven bytes of 0x55, one start byte of 0xD5, the frame body, and a four-byte trailer holding the FCS. The host programs the buffer's byte address, then writes the total byte count. A nonzero count starts a transfer.

The block first checks the count against the legal window of 64 to 1530 bytes. It then reads the buffer one byte per cycle from a synchronous memory port with one cycle of read latency. All eight prefix bytes are verified before any byte leaves the block. Only the body is put on the output byte stream. The body runs from offset 8 up to and including offset count-5, and it carries start and end markers. On success the count register returns to zero and a one-cycle interrupt is raised. On any rejection the count register also returns to zero, nothing is emitted, and a sticky error flag is set so the host can correct the buffer and retry.

CRC generation, line coding and collision handling belong to other blocks.

Top module: `tx_frame_launcher`

## Requirements
- R1: After reset the count register reads 0, the stream is idle, and both the interrupt and the error flag are low.
- R2: A transfer starts only on a write of a nonzero value to the count register (select code 2). Writing 0 produces no memory read, no output byte and no interrupt.
- R3: While the transmit-reset bit (bit 2 of the setup register, select code 0) is 1, a count write stores its value but starts nothing: no output and no interrupt.
- R4: A count below 64 or above 1530 is rejected. The block emits no output, raises no interrupt, sets the error flag and clears the count register. Counts of exactly 64 and 1530 are accepted.
- R5: When any of the first eight buffer bytes differs from 0x55 (offsets 0 to 6) or 0xD5 (offset 7), the frame is rejected. Not a single output byte appears, no interrupt is raised, the error flag is set and the count register is cleared.
- R6: An accepted frame produces exactly count-12 output bytes, equal to buffer offsets 8 through count-5 in order. The start marker is on the first byte only and the end marker is on the last byte only.
- R7: After an accepted frame the count register reads 0 and the interrupt is high for exactly one cycle. A successful start clears the error flag.
- R8: A count write while a transfer is in progress (or about to start) is ignored and does not change the frame being sent.
- R9: The buffer is read starting at the byte address written to the base register (select code 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 setup, 1 base address, 2 count |
| cfg_wdata | input | 32 | Register write data |
| cnt_o | output | 32 | Current value of the count register |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory byte address |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_sof | output | 1 | First body byte |
| tx_eof | output | 1 | Last body byte |
| tx_irq | output | 1 | One-cycle completion pulse |
| tx_err | output | 1 | Sticky rejection flag |

## Verification
The hardest case is a prefix that is wrong only in its last byte. The verdict arrives in the same cycle as the read for the first body byte is issued, so any slip in the gating would leak one body byte onto the stream. The stimulus builds buffers whose prefix is corrupted at offset 7, and also at offsets 0 and 3, with a valid body behind each, and then confirms that the stream stays completely silent. A count rewrite issued a few cycles into a running transfer exercises the ignore path while memory reads are in flight.

// File: rtl/txl_pkg.sv
package txl_pkg;
  typedef enum logic [1:0] {
    SEL_SETUP = 2'd0,
    SEL_BASE  = 2'd1,
    SEL_COUNT = 2'd2
  } cfg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } tx_state_e;

  localparam logic [7:0] PRE_BYTE    = 8'h55;
  localparam logic [7:0] SFD_BYTE    = 8'hD5;
  localparam int         PREFIX_LEN  = 8;
  localparam int         TRAILER_LEN = 4;
endpackage

// File: rtl/txl_regs.sv
module txl_regs
  import txl_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int RST_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] wdata,
  input  logic          busy_i,
  input  logic          clear_i,
  output logic [AW-1:0] base_o,
  output logic [DW-1:0] count_o,
  output logic          start_o
);
  logic          txrst_q, txrst_d;
  logic [AW-1:0] base_q, base_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          start_q, start_d;
  logic          locked;

  assign locked = busy_i | start_q;

  always_comb begin
    txrst_d = txrst_q;
    base_d  = base_q;
    cnt_d   = cnt_q;
    start_d = 1'b0;
    if (we) begin
      case (sel)
        SEL_SETUP: txrst_d = wdata[RST_BIT];
        SEL_BASE:  base_d  = wdata[AW-1:0];
        SEL_COUNT: if (!locked) begin
          cnt_d   = wdata;
          start_d = (wdata != '0) && !txrst_q;
        end
        default: ;
      endcase
    end
    if (clear_i) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrst_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      txrst_q <= txrst_d;
      base_q  <= base_d;
      cnt_q   <= cnt_d;
      start_q <= start_d;
    end
  end

  assign base_o  = base_q;
  assign count_o = cnt_q;
  assign start_o = start_q;

  // R8: a count write during a transfer leaves the register alone
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == SEL_COUNT && locked && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/txl_ctrl.sv
module txl_ctrl
  import txl_pkg::*;
#(
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530,
  localparam int IW     = $clog2(MAX_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] count_i,
  input  logic          abort_i,
  input  logic          last_i,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          tag_vld_o,
  output logic [IW-1:0] tag_idx_o,
  output logic [IW-1:0] len_o,
  output logic          active_o,
  output logic          busy_o,
  output logic          clear_o,
  output logic          irq_o,
  output logic          err_o
);
  localparam logic [DW-1:0] MIN_C = DW'(MIN_LEN);
  localparam logic [DW-1:0] MAX_C = DW'(MAX_LEN);
  localparam logic [IW-1:0] TRL_C = IW'(TRAILER_LEN);

  tx_state_e     state_q, state_d;
  logic [IW-1:0] issue_q, issue_d;
  logic [IW-1:0] len_q, len_d;
  logic [AW-1:0] base_q, base_d;
  logic          vld_q, idx_vld_d;
  logic [IW-1:0] idx_q;
  logic          irq_q, irq_d;
  logic          err_q, err_d;
  logic          reject, finish, rd_en;

  always_comb begin
    state_d = state_q;
    issue_d = issue_q;
    len_d   = len_q;
    base_d  = base_q;
    err_d   = err_q;
    reject  = 1'b0;
    finish  = 1'b0;
    rd_en   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (count_i < MIN_C || count_i > MAX_C) begin
          reject = 1'b1;
        end else begin
          state_d = ST_RUN;
          issue_d = '0;
          len_d   = count_i[IW-1:0];
          base_d  = base_i;
          err_d   = 1'b0;
        end
      end
      ST_RUN: begin
        rd_en = !abort_i && (issue_q < len_q - TRL_C);
        if (rd_en) issue_d = issue_q + 1'b1;
        if (abort_i) begin
          reject  = 1'b1;
          state_d = ST_IDLE;
        end else if (last_i) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (reject) err_d = 1'b1;
    irq_d     = finish;
    idx_vld_d = rd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      issue_q <= '0;
      len_q   <= '0;
      base_q  <= '0;
      vld_q   <= 1'b0;
      idx_q   <= '0;
      irq_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      issue_q <= issue_d;
      len_q   <= len_d;
      base_q  <= base_d;
      vld_q   <= idx_vld_d;
      idx_q   <= issue_q;
      irq_q   <= irq_d;
      err_q   <= err_d;
    end
  end

  assign rd_en_o   = rd_en;
  assign rd_addr_o = base_q + AW'(issue_q);
  assign tag_vld_o = vld_q;
  assign tag_idx_o = idx_q;
  assign len_o     = len_q;
  assign active_o  = (state_q == ST_RUN);
  assign busy_o    = (state_q == ST_RUN);
  assign clear_o   = reject | finish;
  assign irq_o     = irq_q;
  assign err_o     = err_q;

  // R7: the completion pulse lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R4: a rejection never coincides with a completion pulse
  p_err_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !irq_q);
endmodule

// File: rtl/txl_framer.sv
module txl_framer
  import txl_pkg::*;
#(
  parameter int IW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active_i,
  input  logic          vld_i,
  input  logic [IW-1:0] idx_i,
  input  logic [IW-1:0] len_i,
  input  logic [7:0]    data_i,
  output logic          abort_o,
  output logic          last_o,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic          out_sof,
  output logic          out_eof
);
  localparam logic [IW-1:0] PFX_C  = IW'(PREFIX_LEN);
  localparam logic [IW-1:0] LAST_C = IW'(TRAILER_LEN + 1);

  logic       bad_q, bad_d;
  logic       take, in_pfx, mis;
  logic [7:0] expect_b;

  always_comb begin
    take     = vld_i && active_i;
    in_pfx   = idx_i < PFX_C;
    expect_b = (idx_i == PFX_C - 1'b1) ? SFD_BYTE : PRE_BYTE;
    mis      = take && in_pfx && (data_i != expect_b);
    bad_d    = active_i ? (bad_q | mis) : 1'b0;
    abort_o  = take && (idx_i == PFX_C - 1'b1) && (bad_q | mis);
    out_valid = take && !in_pfx;
    out_data  = data_i;
    out_sof   = out_valid && (idx_i == PFX_C);
    out_eof   = out_valid && (idx_i == len_i - LAST_C);
    last_o    = out_eof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end

  // R5: nothing is emitted in the cycle after a rejected prefix
  p_quiet_after_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !out_valid);
  // R6: start and end markers never fall on the same byte
  p_sof_not_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> !out_eof);
endmodule

// File: rtl/tx_frame_launcher.sv
module tx_frame_launcher #(
  parameter int DW      = 32,
  parameter int AW      = 16,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 1530,
  parameter int RST_BIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cnt_o,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          tx_valid,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof,
  output logic          tx_irq,
  output logic          tx_err
);
  localparam int IW = $clog2(MAX_LEN + 1);

  logic [AW-1:0] base;
  logic          start, busy, clear, abort, last, active, tag_vld;
  logic [IW-1:0] tag_idx, len;

  txl_regs #(.DW(DW), .AW(AW), .RST_BIT(RST_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .busy_i(busy), .clear_i(clear), .base_o(base), .count_o(cnt_o),
    .start_o(start)
  );

  txl_ctrl #(.DW(DW), .AW(AW), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .count_i(cnt_o),
    .abort_i(abort), .last_i(last), .rd_en_o(mem_rd_en),
    .rd_addr_o(mem_rd_addr), .tag_vld_o(tag_vld), .tag_idx_o(tag_idx),
    .len_o(len), .active_o(active), .busy_o(busy), .clear_o(clear),
    .irq_o(tx_irq), .err_o(tx_err)
  );

  txl_framer #(.IW(IW)) u_framer (
    .clk(clk), .rst_n(rst_n), .active_i(active), .vld_i(tag_vld),
    .idx_i(tag_idx), .len_i(len), .data_i(mem_rd_data), .abort_o(abort),
    .last_o(last), .out_valid(tx_valid), .out_data(tx_data),
    .out_sof(tx_sof), .out_eof(tx_eof)
  );

  // R7: the count register already reads zero while the pulse is high
  p_irq_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> (cnt_o == '0));
endmodule

// File: tb/tx_frame_launcher_bench.sv
module tx_frame_launcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cnt_o;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = 8'h00;
  logic        tx_valid, tx_sof, tx_eof, tx_irq, tx_err;
  logic [7:0]  tx_data;

  always #4 clk = ~clk;

  tx_frame_launcher u_tx_frame_launcher (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cnt_o(cnt_o), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_eof(tx_eof), .tx_irq(tx_irq), .tx_err(tx_err)
  );

  logic [7:0] mem [0:4095];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[11:0]];

  int checks = 0, errors = 0;
  int cap_n, sof_n, eof_n, sof_at, eof_at, irq_n, rd_n;
  logic [7:0] cap [0:2047];

  always @(negedge clk) begin
    if (tx_valid) begin
      if (tx_sof) begin sof_n++; sof_at = cap_n; end
      if (tx_eof) begin eof_n++; eof_at = cap_n; end
      cap[cap_n] = tx_data;
      cap_n++;
    end
    if (tx_irq) irq_n++;
    if (mem_rd_en) rd_n++;
  end

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mon_clear();
    cap_n = 0; sof_n = 0; eof_n = 0; sof_at = -1; eof_at = -1;
    irq_n = 0; rd_n = 0;
  endtask

  task automatic cfg_write(int sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_wdata = 32'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [7:0] body_byte(int base, int i);
    return 8'((i * 13 + base * 7 + 3) & 8'hff);
  endfunction

  task automatic fill(int base, int len, int bad_pos);
    for (int i = 0; i < len; i++) begin
      if (i < 7)       mem[base + i] = 8'h55;
      else if (i == 7) mem[base + i] = 8'hD5;
      else             mem[base + i] = body_byte(base, i);
    end
    if (bad_pos >= 0) mem[base + bad_pos] = mem[base + bad_pos] ^ 8'h01;
  endtask

  task automatic run_good(int base, int len, string req);
    int bad = 0;
    fill(base, len, -1);
    mon_clear();
    cfg_write(1, base);
    cfg_write(2, len);
    repeat (len + 20) @(negedge clk);
    check(cap_n, len - 12, {req, " byte count"});
    for (int k = 0; k < len - 12 && k < cap_n; k++)
      if (cap[k] != body_byte(base, k + 8)) bad++;
    check(bad, 0, {req, " body mismatches"});
    check(sof_n, 1, {req, " sof count"});
    check(sof_at, 0, {req, " sof position"});
    check(eof_n, 1, {req, " eof count"});
    check(eof_at, len - 13, {req, " eof position"});
    check(irq_n, 1, "R7 irq pulse count");
    check(int'(cnt_o), 0, "R7 count cleared");
    check(int'(tx_err), 0, "R7 error cleared");
  endtask

  task automatic run_bad(int base, int len, int bad_pos, string req);
    fill(base, (len > 1600) ? 1600 : len, bad_pos);
    mon_clear();
    cfg_write(1, base);
    cfg_write(2, len);
    repeat (40) @(negedge clk);
    check(cap_n, 0, {req, " no output"});
    check(irq_n, 0, {req, " no irq"});
    check(int'(cnt_o), 0, {req, " count cleared"});
    check(int'(tx_err), 1, {req, " error set"});
  endtask

  task automatic t_reset();
    check(int'(cnt_o), 0, "R1 count");
    check(int'(tx_valid), 0, "R1 valid");
    check(int'(tx_irq), 0, "R1 irq");
    check(int'(tx_err), 0, "R1 err");
  endtask

  task automatic t_zero_write();
    mon_clear();
    cfg_write(2, 0);
    repeat (30) @(negedge clk);
    check(rd_n, 0, "R2 no read on zero");
    check(cap_n, 0, "R2 no output on zero");
    check(irq_n, 0, "R2 no irq on zero");
  endtask

  task automatic t_txreset();
    fill(0, 100, -1);
    mon_clear();
    cfg_write(0, 4);
    cfg_write(1, 0);
    cfg_write(2, 100);
    repeat (140) @(negedge clk);
    check(cap_n, 0, "R3 no output in reset");
    check(irq_n, 0, "R3 no irq in reset");
    check(int'(cnt_o), 100, "R3 count stored");
    cfg_write(0, 0);
  endtask

  task automatic t_busy();
    int bad = 0;
    fill(600, 100, -1);
    mon_clear();
    cfg_write(1, 600);
    cfg_write(2, 100);
    repeat (3) @(negedge clk);
    cfg_write(2, 70);
    repeat (140) @(negedge clk);
    check(cap_n, 88, "R8 length unchanged");
    for (int k = 0; k < 88 && k < cap_n; k++)
      if (cap[k] != body_byte(600, k + 8)) bad++;
    check(bad, 0, "R8 body unchanged");
    check(irq_n, 1, "R8 single completion");
    check(int'(cnt_o), 0, "R8 count cleared");
  endtask

  initial begin
    mon_clear();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_zero_write();
    run_good(200, 64, "R4 min length R6");
    run_good(300, 100, "R6 R9 base 300");
    run_good(2000, 1530, "R4 max length R6");
    run_bad(0, 63, -1, "R4 below min");
    run_bad(0, 1531, -1, "R4 above max");
    run_good(1000, 80, "R7 recovery R6");
    run_bad(100, 90, 0, "R5 bad offset 0");
    run_bad(100, 90, 7, "R5 bad offset 7");
    run_bad(100, 90, 3, "R5 bad offset 3");
    t_txreset();
    run_good(50, 72, "R3 after release R6");
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule